// File: doc/BRIEF.md
# Two-Tier Overcurrent Fault Controller

This block guards one switched output channel. Each clock it compares a digital current sample against two limits chosen by small codes: a lower limit that may be exceeded for a programmable grace period, and a higher limit that is never tolerated. If the current stays above the lower limit for the whole grace period, the channel is shut off. If it rises above the higher limit, the channel is shut off on the next clock edge. Either way the shut-off is held until the on request is withdrawn and then asserted again. This gives the behaviour of a slow-blow fuse with a fast-blow backstop.

Current arrives as an unsigned number in half-ampere units. The grace period is counted in pulses of a timebase tick, which has a 10 µs period. A disable input stops the lower limit from ever causing a shut-off. The higher limit still applies when that input is set.

The controller is a five-state machine:
- `ST_IDLE`: channel off, no fault.
- `ST_RUN`: channel on, current within limits.
- `ST_BLANK`: channel on, lower limit exceeded, grace period counting.
- `ST_TRIP`: fault held, request still high.
- `ST_REARM`: fault held, request seen low.

The transitions are:
- `IDLE→RUN`: the request is high.
- `RUN→BLANK`: the lower limit is exceeded and the disable input is 0.
- `BLANK→RUN`: the current is back at or below the lower limit, or the disable input is set.
- `RUN→TRIP` and `BLANK→TRIP`: the higher limit is exceeded.
- `BLANK→TRIP`: the grace period expires.
- `RUN→IDLE` and `BLANK→IDLE`: the request is low. This has the highest priority.
- `TRIP→REARM`: the request is low.
- `REARM→RUN`: the request is high.

Top module: `oc_fault_ctl`

## Requirements
- R1: After reset, `gate_en` and `fault_latched` are both 0.
- R2: With no overcurrent, `gate_en` goes to 1 on the clock edge after `req` is sampled high. It goes to 0 on the clock edge after `req` is sampled low.
- R3: Current is exceeded only when it is strictly greater than the limit, in half-ampere units.
  - The lower limit is 50 − 5·`lo_code`, so code 0 gives 50 and code 7 gives 15.
  - The higher limit is 200 when `hi_code` is 0 and 150 when `hi_code` is 1.
- R4: While the channel is on and `req` is high, a sample above the higher limit sets `fault_latched` to 1 and `gate_en` to 0 on the next clock edge. This applies whatever the disable input or the grace state is.
- R5: When the lower limit is exceeded and `lo_dis` is 0, the grace period starts.
  - The next edge enters grace and `gate_en` stays 1.
  - Ticks sampled while in grace are counted. On the edge that samples the N-th such tick, `gate_en` goes to 0 and `fault_latched` goes to 1.
  - N is 15500 for `blank_code` 00, 1000 for 01, 120 for 10 and 15 for 11.
- R6: If the current falls to or below the lower limit before the grace period expires, the tick count is discarded. A later exceedance needs the full N ticks again.
- R7: With `lo_dis` = 1, exceeding only the lower limit never sets `fault_latched`.
- R8: The fault clears only through a low-then-high sequence on `req`.
  - Once set, `fault_latched` stays 1 and `gate_en` stays 0 while `req` stays high.
  - Driving `req` low keeps the fault set.
  - Driving `req` high again clears `fault_latched` and sets `gate_en` on the next edge.
- R9: `gate_en` and `fault_latched` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse, 10 µs period |
| req | input | 1 | Channel on request |
| cur | input | CUR_W (9) | Current sample, unsigned, 0.5 A units |
| lo_code | input | 3 | Lower-limit select |
| hi_code | input | 1 | Higher-limit select |
| blank_code | input | 2 | Grace-period select |
| lo_dis | input | 1 | 1 = lower limit never trips |
| gate_en | output | 1 | Effective channel enable |
| fault_latched | output | 1 | Overcurrent shut-off held |

## Verification
The sample is held exactly at each limit and then one step above it, for both extreme lower codes and both higher codes. This separates a strict comparison from an inclusive one and a wrong threshold formula from a right one. Every grace code is run to one tick short of expiry and then to expiry, which shows the exact tick count of each code. A dip below the limit part-way through grace shows whether the count restarts or resumes. The higher limit is applied with the disable input set and during grace, which shows that the fast path ignores both.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_BLANK,
        ST_TRIP,
        ST_REARM
    } oc_state_t;

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/oc_thresh.sv
module oc_thresh #(
    parameter int CUR_W   = 9,
    parameter int LO_BASE = 50,
    parameter int LO_STEP = 5,
    parameter int HI_THR0 = 200,
    parameter int HI_THR1 = 150
) (
    input  logic [CUR_W-1:0] cur,
    input  logic [2:0]       lo_code,
    input  logic             hi_code,
    output logic             lo_over,
    output logic             hi_over
);
    logic [CUR_W-1:0] lo_thr;
    logic [CUR_W-1:0] hi_thr;

    always_comb begin
        lo_thr  = CUR_W'(LO_BASE) - CUR_W'(LO_STEP) * CUR_W'(lo_code);
        hi_thr  = hi_code ? CUR_W'(HI_THR1) : CUR_W'(HI_THR0);
        lo_over = cur > lo_thr;
        hi_over = cur > hi_thr;
    end
endmodule

// File: rtl/oc_blank_timer.sv
module oc_blank_timer #(
    parameter int CNT_W = 14,
    parameter int T00   = 15500,
    parameter int T01   = 1000,
    parameter int T10   = 120,
    parameter int T11   = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic [1:0] code,
    output logic       expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        unique case (code)
            2'b00:   limit = CNT_W'(T00);
            2'b01:   limit = CNT_W'(T01);
            2'b10:   limit = CNT_W'(T10);
            default: limit = CNT_W'(T11);
        endcase
        expire = run && tick && (cnt_q == limit - CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!run)    cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/oc_fault_ctl.sv
module oc_fault_ctl
    import oc_pkg::*;
#(
    parameter int CUR_W   = 9,
    parameter int LO_BASE = 50,
    parameter int LO_STEP = 5,
    parameter int HI_THR0 = 200,
    parameter int HI_THR1 = 150,
    parameter int T00     = 15500,
    parameter int T01     = 1000,
    parameter int T10     = 120,
    parameter int T11     = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             req,
    input  logic [CUR_W-1:0] cur,
    input  logic [2:0]       lo_code,
    input  logic             hi_code,
    input  logic [1:0]       blank_code,
    input  logic             lo_dis,
    output logic             gate_en,
    output logic             fault_latched
);
    localparam int TMAX  = max4(T00, T01, T10, T11);
    localparam int CNT_W = $clog2(TMAX + 1);

    oc_state_t st_q, st_d;
    logic      lo_over, hi_over, expire, in_blank;

    oc_thresh #(
        .CUR_W(CUR_W), .LO_BASE(LO_BASE), .LO_STEP(LO_STEP),
        .HI_THR0(HI_THR0), .HI_THR1(HI_THR1)
    ) u_thr (
        .cur(cur), .lo_code(lo_code), .hi_code(hi_code),
        .lo_over(lo_over), .hi_over(hi_over)
    );

    assign in_blank = (st_q == ST_BLANK);

    oc_blank_timer #(
        .CNT_W(CNT_W), .T00(T00), .T01(T01), .T10(T10), .T11(T11)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(in_blank), .tick(tick),
        .code(blank_code), .expire(expire)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req) st_d = ST_RUN;
            ST_RUN: begin
                if (!req)                     st_d = ST_IDLE;
                else if (hi_over)             st_d = ST_TRIP;
                else if (lo_over && !lo_dis)  st_d = ST_BLANK;
            end
            ST_BLANK: begin
                if (!req)                     st_d = ST_IDLE;
                else if (hi_over || expire)   st_d = ST_TRIP;
                else if (!lo_over || lo_dis)  st_d = ST_RUN;
            end
            ST_TRIP:  if (!req) st_d = ST_REARM;
            ST_REARM: if (req)  st_d = ST_RUN;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        gate_en       = 1'b0;
        fault_latched = 1'b0;
        unique case (st_q)
            ST_RUN, ST_BLANK:  gate_en       = 1'b1;
            ST_TRIP, ST_REARM: fault_latched = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/oc_fault_ctl_chk.sv
module oc_fault_ctl_chk #(
    parameter int CUR_W   = 9,
    parameter int HI_THR0 = 200,
    parameter int HI_THR1 = 150
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             req,
    input logic [CUR_W-1:0] cur,
    input logic [2:0]       lo_code,
    input logic             hi_code,
    input logic [1:0]       blank_code,
    input logic             lo_dis,
    input logic             gate_en,
    input logic             fault_latched
);
    logic [CUR_W-1:0] hi_lim;
    assign hi_lim = hi_code ? CUR_W'(HI_THR1) : CUR_W'(HI_THR0);

    assert_gate_fault_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_en && fault_latched));

    assert_hi_fast_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && req && cur > hi_lim) |=> (fault_latched && !gate_en));

    assert_req_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !gate_en);

    assert_lo_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && req && lo_dis && cur <= hi_lim) |=> !fault_latched);

    assert_clear_on_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_latched) |-> (gate_en && $past(req)));
endmodule

bind oc_fault_ctl oc_fault_ctl_chk #(
    .CUR_W(CUR_W), .HI_THR0(HI_THR0), .HI_THR1(HI_THR1)
) u_chk (.*);

// File: tb/sim_oc_fault_ctl.sv
module sim_oc_fault_ctl;
    localparam int CUR_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             req = 1'b0;
    logic [CUR_W-1:0] cur = '0;
    logic [2:0]       lo_code = '0;
    logic             hi_code = 1'b0;
    logic [1:0]       blank_code = '0;
    logic             lo_dis = 1'b0;
    logic             gate_en, fault_latched;

    typedef struct {
        logic  g;
        logic  f;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    always #5 clk = ~clk;

    oc_fault_ctl u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .cur(cur),
        .lo_code(lo_code), .hi_code(hi_code), .blank_code(blank_code),
        .lo_dis(lo_dis), .gate_en(gate_en), .fault_latched(fault_latched)
    );

    // monitor: pops expectations and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (gate_en !== e.g || fault_latched !== e.f) begin
                    errors++;
                    $display("FAIL %s: gate/fault = %b%b expected %b%b",
                             e.tag, gate_en, fault_latched, e.g, e.f);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(logic g, logic f, string tag);
        exp_t e;
        e.g = g; e.f = f; e.tag = tag;
        q.push_back(e);
        wait (q.size() == 0);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step();
            tick = 1'b0; step(); step(); step();
        end
    endtask

    // fresh on state with zero current
    task automatic restart();
        cur = '0; req = 1'b0; step();
        req = 1'b1; step();
    endtask

    task automatic blank_trip(logic [2:0] lc, logic [1:0] bc, int lim, string tag);
        restart();
        lo_code = lc; blank_code = bc;
        cur = CUR_W'(50 - 5 * int'(lc) + 1);
        step();
        ticks(lim - 1);
        expect_out(1'b1, 1'b0, {tag, " one tick short"});
        ticks(1);
        expect_out(1'b0, 1'b1, {tag, " expiry"});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run incomplete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        expect_out(1'b0, 1'b0, "R1 reset state");
        rst_n = 1'b1;
        step();
        expect_out(1'b0, 1'b0, "R1 after release");

        req = 1'b1; step();
        expect_out(1'b1, 1'b0, "R2 request on");
        req = 1'b0; step();
        expect_out(1'b0, 1'b0, "R2 request off");

        // R3 boundary at lower limit, code 0 -> 50
        restart();
        lo_code = 3'd0; blank_code = 2'b11; cur = 9'd50;
        ticks(20);
        expect_out(1'b1, 1'b0, "R3 at lower limit code0");
        // R5 code 11 -> 15 ticks
        blank_trip(3'd0, 2'b11, 15, "R5 code11");
        // R8 hold and rearm
        step(); step();
        expect_out(1'b0, 1'b1, "R8 held with req high");
        req = 1'b0; step();
        expect_out(1'b0, 1'b1, "R8 held after req low");
        req = 1'b1; step();
        expect_out(1'b1, 1'b0, "R8 cleared on req high");

        // R3 lower code 7 -> 15
        restart();
        lo_code = 3'd7; blank_code = 2'b11; cur = 9'd15;
        ticks(20);
        expect_out(1'b1, 1'b0, "R3 at lower limit code7");
        blank_trip(3'd7, 2'b11, 15, "R3 code7 over");

        // R6 restart of count
        restart();
        lo_code = 3'd0; blank_code = 2'b11; cur = 9'd51;
        step();
        ticks(10);
        cur = 9'd50; step();
        cur = 9'd51; step();
        ticks(14);
        expect_out(1'b1, 1'b0, "R6 count restarted");
        ticks(1);
        expect_out(1'b0, 1'b1, "R6 full window after dip");

        // R7 disabled lower limit
        restart();
        lo_dis = 1'b1; lo_code = 3'd0; blank_code = 2'b11; cur = 9'd120;
        ticks(40);
        expect_out(1'b1, 1'b0, "R7 lower limit disabled");

        // R4 higher limit, both codes, with disable set
        hi_code = 1'b0; cur = 9'd200; step(); step();
        expect_out(1'b1, 1'b0, "R4 at higher limit 200");
        cur = 9'd201; step();
        expect_out(1'b0, 1'b1, "R4 above 200");
        restart();
        hi_code = 1'b1; cur = 9'd150; step(); step();
        expect_out(1'b1, 1'b0, "R4 at higher limit 150");
        cur = 9'd151; step();
        expect_out(1'b0, 1'b1, "R4 above 150");
        lo_dis = 1'b0; hi_code = 1'b0;

        // R4 during grace
        restart();
        lo_code = 3'd0; blank_code = 2'b00; cur = 9'd60;
        step(); ticks(3);
        expect_out(1'b1, 1'b0, "R4 in grace before high");
        cur = 9'd250; step();
        expect_out(1'b0, 1'b1, "R4 high overrides grace");

        // R5 remaining codes
        blank_trip(3'd0, 2'b10, 120,   "R5 code10");
        blank_trip(3'd2, 2'b01, 1000,  "R5 code01");
        blank_trip(3'd0, 2'b00, 15500, "R5 code00");

        // R2 off after clear
        restart();
        expect_out(1'b1, 1'b0, "R2 on after restart");
        req = 1'b0; step();
        expect_out(1'b0, 1'b0, "R2 off final");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule